// File: doc/BRIEF.md
# DMA Request and Channel Status Register Slice

This block is the register slice of a multi-channel DMA controller that holds software burst requests and shows channel status. Software reaches it over a 32-bit register bus with a valid/ready handshake. Each bus access is accepted in the cycle it is first seen. The handshake completes one cycle later with read data.

Software raises a burst request on any of 16 request lines by writing a 1 into that line's bit. The bit stays pending until the controller reports, with a one-cycle pulse on that line, that the transaction has completed. The pending bits are ORed with the peripheral request lines, and the result goes to the controller.

Two read-only views sit beside the request register. The first is an 8-bit enabled-channel register. Its bits are set by enable pulses and cleared by per-channel completion pulses. The second is an 8-bit raw error view of the controller's error request lines.

Top module: `dma_req_status_regs`

## Requirements
- R1: After reset the request register and the enabled-channel register are 0, `bus_ready` is 0 and `ctrl_req` equals `periph_req`.
- R2: A write to offset 0x020 sets every request bit whose `bus_wdata` bit in 15:0 is 1. Data bits that are 0 leave their request bits unchanged, and bits 31:16 of the data are ignored.
- R3: A one-cycle pulse on `line_done[i]` clears request bit i at the next clock edge.
- R4: When a software set and a `line_done` clear reach the same request bit on the same edge, the bit ends up 1.
- R5: A read at offset 0x020 returns the pending request bits in 15:0 and 0 in bits 31:16.
- R6: `ctrl_req[i]` is 1 whenever request bit i is pending or `periph_req[i]` is 1.
- R7: A pulse on `chan_enable_set[c]` sets enabled bit c, and a pulse on `chan_done[c]` clears it. If both arrive together, the set wins. The bits appear on `chan_enabled` and are read at offset 0x01C in bits 7:0, with 0 above.
- R8: A read at offset 0x018 returns `chan_err[7:0]` as sampled in the accept cycle, with 0 above bit 7.
- R9: Writes to 0x018, 0x01C or any unmapped offset change no state, and reads of unmapped offsets return 0.
- R10: An access is accepted in a cycle where `bus_valid` is 1 and `bus_ready` is 0. `bus_ready` is 1 for exactly the following cycle, and `bus_rdata` is valid during that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access request, held until `bus_ready` |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Access complete, read data valid |
| bus_rdata | output | 32 | Read data |
| periph_req | input | 16 | Peripheral request lines |
| line_done | input | 16 | Per-line transaction-complete pulses |
| ctrl_req | output | 16 | Combined requests to the controller |
| chan_enable_set | input | 8 | Per-channel enable pulses |
| chan_done | input | 8 | Per-channel transfer-complete pulses |
| chan_err | input | 8 | Raw per-channel error request levels |
| chan_enabled | output | 8 | Enabled-channel status |

## Verification
A software write of 1 and a hardware completion pulse can land on the same request bit in the same cycle. An enable pulse and a completion pulse can likewise meet on one channel bit. The bench provokes the first case by raising `line_done` in the same cycle it presents a write to 0x020. One pulsed bit is also being written, and a second pulsed bit is not. The bench then reads back the register and expects the written bit to survive and the other to clear. The channel case is driven the same way, by pulsing `chan_enable_set` and `chan_done` together and reading 0x01C.

// File: rtl/dma_rs_pkg.sv
package dma_rs_pkg;
    localparam int BUS_W = 32;
    localparam logic [11:0] OFS_ERR  = 12'h018;
    localparam logic [11:0] OFS_EN   = 12'h01C;
    localparam logic [11:0] OFS_SOFT = 12'h020;

    typedef struct packed {
        logic             ready;
        logic [BUS_W-1:0] rdata;
    } bus_state_t;
endpackage

// File: rtl/dma_rs_flagreg.sv
module dma_rs_flagreg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic [W-1:0] clr,
    output logic [W-1:0] q
);
    logic [W-1:0] flags_d, flags_q;

    // set has priority over clear so that a fresh request is never lost
    always_comb begin
        flags_d = (flags_q & ~clr) | set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign q = flags_q;

    assert_clear_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr & ~set)) |=> ((q & $past(clr & ~set)) == '0));
    assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|set) |=> ((q & $past(set)) == $past(set)));
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (set == '0 && clr == '0) |=> $stable(q));
endmodule

// File: rtl/dma_rs_busif.sv
module dma_rs_busif
    import dma_rs_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int N_LINES = 16,
    parameter int N_CHAN  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [BUS_W-1:0]   bus_wdata,
    output logic               bus_ready,
    output logic [BUS_W-1:0]   bus_rdata,
    input  logic [N_LINES-1:0] soft_q,
    input  logic [N_CHAN-1:0]  en_q,
    input  logic [N_CHAN-1:0]  err_in,
    output logic [N_LINES-1:0] soft_set
);
    bus_state_t st_d, st_q;
    logic       accept;
    logic       hit_soft, hit_en, hit_err;
    logic [BUS_W-1:0] rd_mux;

    always_comb begin
        accept   = bus_valid && !st_q.ready;
        hit_soft = (bus_addr == ADDR_W'(OFS_SOFT));
        hit_en   = (bus_addr == ADDR_W'(OFS_EN));
        hit_err  = (bus_addr == ADDR_W'(OFS_ERR));

        rd_mux = '0;
        if (hit_soft)     rd_mux[N_LINES-1:0] = soft_q;
        else if (hit_en)  rd_mux[N_CHAN-1:0]  = en_q;
        else if (hit_err) rd_mux[N_CHAN-1:0]  = err_in;

        soft_set = (accept && bus_write && hit_soft) ? bus_wdata[N_LINES-1:0] : '0;

        st_d.ready = accept;
        st_d.rdata = accept ? rd_mux : st_q.rdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_ready = st_q.ready;
    assign bus_rdata = st_q.rdata;

    assert_ready_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |=> !bus_ready);
    assert_ready_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready) |=> bus_ready);
    assert_rsvd_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready && bus_addr == ADDR_W'(OFS_SOFT))
        |=> (bus_rdata[BUS_W-1:N_LINES] == '0));
    assert_write_only_soft_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != ADDR_W'(OFS_SOFT)) |-> (soft_set == '0));
endmodule

// File: rtl/dma_req_status_regs.sv
module dma_req_status_regs
    import dma_rs_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int N_LINES = 16,
    parameter int N_CHAN  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic               bus_ready,
    output logic [31:0]        bus_rdata,
    input  logic [N_LINES-1:0] periph_req,
    input  logic [N_LINES-1:0] line_done,
    output logic [N_LINES-1:0] ctrl_req,
    input  logic [N_CHAN-1:0]  chan_enable_set,
    input  logic [N_CHAN-1:0]  chan_done,
    input  logic [N_CHAN-1:0]  chan_err,
    output logic [N_CHAN-1:0]  chan_enabled
);
    logic [N_LINES-1:0] soft_q, soft_set;
    logic [N_CHAN-1:0]  en_q;

    dma_rs_busif #(.ADDR_W(ADDR_W), .N_LINES(N_LINES), .N_CHAN(N_CHAN)) u_busif (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
        .soft_q(soft_q), .en_q(en_q), .err_in(chan_err), .soft_set(soft_set)
    );

    dma_rs_flagreg #(.W(N_LINES)) u_soft (
        .clk(clk), .rst_n(rst_n), .set(soft_set), .clr(line_done), .q(soft_q)
    );

    dma_rs_flagreg #(.W(N_CHAN)) u_chan (
        .clk(clk), .rst_n(rst_n), .set(chan_enable_set), .clr(chan_done), .q(en_q)
    );

    assign ctrl_req     = soft_q | periph_req;
    assign chan_enabled = en_q;

    assert_periph_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctrl_req & periph_req) == periph_req));
    assert_chan_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|(chan_done & ~chan_enable_set)) |=> ((chan_enabled & $past(chan_done & ~chan_enable_set)) == '0));
endmodule

// File: tb/test_dma_req_status_regs.sv
`timescale 1ns/1ps
module test_dma_req_status_regs;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        bus_valid = 0, bus_write = 0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ready;
    logic [31:0] bus_rdata;
    logic [15:0] periph_req = '0, line_done = '0, ctrl_req;
    logic [7:0]  chan_enable_set = '0, chan_done = '0, chan_err = '0, chan_enabled;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    dma_req_status_regs i_dma_req_status_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
        .periph_req(periph_req), .line_done(line_done), .ctrl_req(ctrl_req),
        .chan_enable_set(chan_enable_set), .chan_done(chan_done),
        .chan_err(chan_err), .chan_enabled(chan_enabled)
    );

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [31:0] wdata;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    // R2, R5, R9 table; writes carry exp = 0 and are not compared
    localparam vec_t VECS [10] = '{
        '{1'b1, 12'h020, 32'h0000_00A5, 32'h0, 4'd2},
        '{1'b0, 12'h020, 32'h0,         32'h0000_00A5, 4'd5},
        '{1'b1, 12'h020, 32'hFFFF_0100, 32'h0, 4'd2},
        '{1'b0, 12'h020, 32'h0,         32'h0000_01A5, 4'd2},
        '{1'b1, 12'h020, 32'h0000_0000, 32'h0, 4'd2},
        '{1'b0, 12'h020, 32'h0,         32'h0000_01A5, 4'd2},
        '{1'b1, 12'h01C, 32'h0000_00FF, 32'h0, 4'd9},
        '{1'b0, 12'h01C, 32'h0,         32'h0000_0000, 4'd9},
        '{1'b1, 12'h024, 32'hFFFF_FFFF, 32'h0, 4'd9},
        '{1'b0, 12'h024, 32'h0,         32'h0000_0000, 4'd9}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_op(input logic wr, input logic [11:0] a, input logic [31:0] d,
                          output logic [31:0] rd);
        @(negedge clk);
        bus_valid = 1; bus_write = wr; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        chk("R10 ready high", {31'b0, bus_ready}, 32'd1);
        rd = bus_rdata;
        bus_valid = 0; bus_write = 0;
        @(negedge clk);
        chk("R10 ready single", {31'b0, bus_ready}, 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ready", {31'b0, bus_ready}, 32'd0);
        chk("R1 chan_enabled", {24'b0, chan_enabled}, 32'd0);
        periph_req = 16'h8001;
        #1;
        chk("R1 ctrl_req", {16'b0, ctrl_req}, 32'h8001);
        periph_req = '0;
        bus_op(1'b0, 12'h020, 32'h0, rd);
        chk("R1 soft reg", rd, 32'h0);

        for (int i = 0; i < 10; i++) begin
            bus_op(VECS[i].wr, VECS[i].addr, VECS[i].wdata, rd);
            if (!VECS[i].wr)
                chk($sformatf("R%0d vector %0d", VECS[i].req, i), rd, VECS[i].exp);
        end

        // R6 OR with peripheral lines (soft = 0x01A5)
        periph_req = 16'h8002;
        #1;
        chk("R6 ctrl_req", {16'b0, ctrl_req}, 32'h81A7);
        periph_req = '0;

        // R3 completion clears one line
        @(negedge clk); line_done = 16'h0001;
        @(negedge clk); line_done = '0;
        chk("R3 ctrl_req after done", {16'b0, ctrl_req}, 32'h01A4);
        bus_op(1'b0, 12'h020, 32'h0, rd);
        chk("R3 readback", rd, 32'h0000_01A4);

        // R4 collision: write bit 2 while done pulses bits 2 and 5
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = 12'h020; bus_wdata = 32'h0000_0004;
        line_done = 16'h0024;
        @(negedge clk);
        line_done = '0; bus_valid = 0; bus_write = 0;
        @(negedge clk);
        bus_op(1'b0, 12'h020, 32'h0, rd);
        chk("R4 set wins over done", rd, 32'h0000_0184);

        // R7 channel enables
        @(negedge clk); chan_enable_set = 8'h0F;
        @(negedge clk); chan_enable_set = '0;
        chk("R7 chan_enabled", {24'b0, chan_enabled}, 32'h0F);
        bus_op(1'b0, 12'h01C, 32'h0, rd);
        chk("R7 readback", rd, 32'h0000_000F);
        @(negedge clk); chan_done = 8'h03; chan_enable_set = 8'h02;
        @(negedge clk); chan_done = '0; chan_enable_set = '0;
        chk("R7 done and set collision", {24'b0, chan_enabled}, 32'h0E);

        // R8 raw error view
        chan_err = 8'h5A;
        bus_op(1'b0, 12'h018, 32'h0, rd);
        chk("R8 error readback", rd, 32'h0000_005A);
        bus_op(1'b1, 12'h018, 32'hFFFF_FFFF, rd);
        bus_op(1'b0, 12'h020, 32'h0, rd);
        chk("R9 write to error reg no effect", rd, 32'h0000_0184);
        chk("R9 enables unchanged", {24'b0, chan_enabled}, 32'h0E);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule